// File: doc/BRIEF.md
# Register-Driven Test Trigger Injector

This block lets a slow-control register bus place a single level-1 test trigger into the trigger path. No data queue is involved. Two register writes start a transfer. The first loads a 32-bit preload register that holds the trigger number, a random code and an information byte. The second goes to a start register and carries the trigger type and a short-transfer flag.

When a valid start write arrives, the block builds a 64-bit trigger word from the latched preload fields and the type. It then presents the word on an output with a valid/ready handshake. While a word is waiting to be taken, further start writes are refused and a sticky overrun flag records each one. The preload register keeps its contents between transfers, so a host can send the same fields again with only a start write.

Top module: `tti_injector`

## Requirements
- R1: After reset, `trig_valid` is 0, `start_overrun` is 0 and the preload register holds zero.
- R2: A write to address 0x112 loads the preload register: bits 15:0 are the trigger number, bits 23:16 the random code and bits 31:24 the information byte. A write to address 0x110 with data bit 8 set, made while no word is pending, raises `trig_valid` on the next cycle. The word then carries the type (start data bits 3:0) in bits 3:0, the number in bits 31:16, the random code in bits 39:32 and the information byte in bits 47:40.
- R3: In every presented word, bits 63:48 and bits 15:4 are zero, whatever the other bits of the start or preload data hold.
- R4: A start write with data bit 8 clear launches nothing and leaves `start_overrun` unchanged.
- R5: While `trig_valid` is high and `trig_ready` is low, `trig_valid` stays high and `trig_word` stays constant. After a cycle in which both are high, `trig_valid` is low.
- R6: A start write that arrives while `trig_valid` is high is dropped, even in the cycle in which the word is accepted. The pending word is unchanged and `start_overrun` becomes 1 on the next cycle.
- R7: Once set, `start_overrun` stays 1 until reset.
- R8: A preload write made while a word is pending does not alter that word. The next start write uses the new preload contents.
- R9: Writes to any other address, and bus cycles with `reg_we` low, change neither the preload register nor the output.
- R10: The preload register keeps its value after a launch, so repeated start writes reuse the same number, random code and information byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 16 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Write strobe, one write per cycle high |
| trig_word | output | 64 | Assembled trigger word |
| trig_valid | output | 1 | Trigger word pending |
| trig_ready | input | 1 | Downstream accepts the word |
| start_overrun | output | 1 | Sticky: a start write was refused |

## Verification
The assertions assume that the bus carries at most one write per cycle and that each address and data value is steady during its strobe cycle. They also assume that the downstream side may hold `trig_ready` low for any number of cycles. The bench drives every write and every ready pulse on the falling clock edge and holds the strobe for exactly one cycle. It deliberately issues start writes during pending words, including the acceptance cycle, and during long ready stalls, so that the drop and hold paths are exercised inside those assumptions.

// File: rtl/tti_pkg.sv
package tti_pkg;

    localparam int TYPE_W  = 4;
    localparam int NUM_W   = 16;
    localparam int RND_W   = 8;
    localparam int INFO_W  = 8;
    localparam int WORD_W  = 64;
    localparam int PAD_LO_W = NUM_W - TYPE_W;
    localparam int PAD_HI_W = WORD_W - INFO_W - RND_W - NUM_W - PAD_LO_W - TYPE_W;

    typedef struct packed {
        logic [PAD_HI_W-1:0] pad_hi;
        logic [INFO_W-1:0]   info;
        logic [RND_W-1:0]    rnd;
        logic [NUM_W-1:0]    num;
        logic [PAD_LO_W-1:0] pad_lo;
        logic [TYPE_W-1:0]   ttype;
    } trig_word_t;

    typedef struct packed {
        logic [INFO_W-1:0] info;
        logic [RND_W-1:0]  rnd;
        logic [NUM_W-1:0]  num;
    } preload_t;

endpackage

// File: rtl/tti_decode.sv
module tti_decode #(
    parameter int          ADDR_W       = 16,
    parameter int          DATA_W       = 32,
    parameter logic [15:0] PRELOAD_ADDR = 16'h0112,
    parameter logic [15:0] START_ADDR   = 16'h0110,
    parameter int          SHORT_BIT    = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    output logic              preload_hit,
    output logic              start_go
);

    localparam logic [ADDR_W-1:0] PRE_A = ADDR_W'(PRELOAD_ADDR);
    localparam logic [ADDR_W-1:0] STA_A = ADDR_W'(START_ADDR);

    always_comb begin
        preload_hit = we && (addr == PRE_A);
        start_go    = we && (addr == STA_A) && wdata[SHORT_BIT];
    end

endmodule

// File: rtl/tti_preload.sv
module tti_preload
    import tti_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output preload_t          preload_q
);

    localparam int PL_W = $bits(preload_t);

    preload_t preload_d;

    always_comb begin
        preload_d = preload_q;
        if (load) begin
            preload_d = preload_t'(wdata[PL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preload_q <= '0;
        end else begin
            preload_q <= preload_d;
        end
    end

    // R9: without a load the stored fields do not move
    assert_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(preload_q));

endmodule

// File: rtl/tti_launch.sv
module tti_launch
    import tti_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_go,
    input  logic [3:0] start_type,
    input  preload_t   preload_q,
    input  logic       out_ready,
    output trig_word_t out_word,
    output logic       out_valid,
    output logic       overrun
);

    typedef struct packed {
        logic       valid;
        logic       overrun;
        trig_word_t word;
    } launch_st_t;

    launch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && out_ready) begin
            st_d.valid = 1'b0;
        end
        if (start_go) begin
            if (st_q.valid) begin
                st_d.overrun = 1'b1;
            end else begin
                st_d.valid        = 1'b1;
                st_d.word.pad_hi  = '0;
                st_d.word.info    = preload_q.info;
                st_d.word.rnd     = preload_q.rnd;
                st_d.word.num     = preload_q.num;
                st_d.word.pad_lo  = '0;
                st_d.word.ttype   = start_type;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_word  = st_q.word;
    assign out_valid = st_q.valid;
    assign overrun   = st_q.overrun;

    // R2: an accepted start shows up one cycle later
    assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && start_go) |=> out_valid);

    // R5: stalled word is held unchanged
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    // R5: handshake completes the transfer
    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> !out_valid);

    // R6: start during a pending word is refused and flagged
    assert_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && start_go) |=> (overrun && $stable(out_word)));

    // R7: overrun is sticky
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

// File: rtl/tti_injector.sv
module tti_injector
    import tti_pkg::*;
#(
    parameter int          ADDR_W       = 16,
    parameter int          DATA_W       = 32,
    parameter logic [15:0] PRELOAD_ADDR = 16'h0112,
    parameter logic [15:0] START_ADDR   = 16'h0110,
    parameter int          SHORT_BIT    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [63:0]       trig_word,
    output logic              trig_valid,
    input  logic              trig_ready,
    output logic              start_overrun
);

    logic       preload_hit;
    logic       start_go;
    preload_t   preload_q;
    trig_word_t word_s;

    tti_decode #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .PRELOAD_ADDR(PRELOAD_ADDR),
        .START_ADDR  (START_ADDR),
        .SHORT_BIT   (SHORT_BIT)
    ) u_decode (
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .we         (reg_we),
        .preload_hit(preload_hit),
        .start_go   (start_go)
    );

    tti_preload #(
        .DATA_W(DATA_W)
    ) u_preload (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (preload_hit),
        .wdata    (reg_wdata),
        .preload_q(preload_q)
    );

    tti_launch u_launch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_go  (start_go),
        .start_type(reg_wdata[TYPE_W-1:0]),
        .preload_q (preload_q),
        .out_ready (trig_ready),
        .out_word  (word_s),
        .out_valid (trig_valid),
        .overrun   (start_overrun)
    );

    assign trig_word = word_s;

    // R3: reserved bit ranges of a presented word are zero
    assert_resv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |-> (trig_word[63:48] == '0 && trig_word[15:4] == '0));

    // R4: start with the short flag clear launches nothing when idle
    assert_noflag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_valid && reg_we && reg_addr == ADDR_W'(START_ADDR)
         && !reg_wdata[SHORT_BIT]) |=> !trig_valid);

endmodule

// File: tb/tti_injector_bench.sv
module tti_injector_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] A_PRE = 16'h0112;
    localparam logic [15:0] A_STA = 16'h0110;

    typedef struct packed {
        logic [31:0] pre;
        logic [31:0] sta;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{32'hCDAB1234, 32'h0000010E, 64'h0000_CDAB_1234_000E},
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 64'h0000_FFFF_FFFF_000F},
        '{32'h00000000, 32'h00000100, 64'h0000_0000_0000_0000},
        '{32'h12345678, 32'h00000105, 64'h0000_1234_5678_0005}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic        trig_ready = 1'b0;
    logic [63:0] trig_word;
    logic        trig_valid;
    logic        start_overrun;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tti_injector u_tti_injector (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_we       (reg_we),
        .trig_word    (trig_word),
        .trig_valid   (trig_valid),
        .trig_ready   (trig_ready),
        .start_overrun(start_overrun)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input bit we);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = we;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic accept();
        @(negedge clk);
        trig_ready = 1'b1;
        @(negedge clk);
        trig_ready = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(trig_valid == 1'b0, "R1 valid", 64'(trig_valid), 64'h0);
        chk(start_overrun == 1'b0, "R1 overrun", 64'(start_overrun), 64'h0);
        rst_n = 1'b1;
        // R1: preload zero, seen through a start without prior preload
        wr(A_STA, 32'h00000103, 1'b1);
        chk(trig_valid && trig_word == 64'h3, "R1 preload zero", trig_word, 64'h3);
        accept();

        // R2 R3 R10: vector table
        for (int i = 0; i < NV; i++) begin
            wr(A_PRE, VECS[i].pre, 1'b1);
            wr(A_STA, VECS[i].sta, 1'b1);
            chk(trig_valid == 1'b1, "R2 valid", 64'(trig_valid), 64'h1);
            chk(trig_word == VECS[i].exp, "R2 R3 word", trig_word, VECS[i].exp);
            accept();
            chk(trig_valid == 1'b0, "R5 release", 64'(trig_valid), 64'h0);
        end
        // R10: reuse last preload with a new type
        wr(A_STA, 32'h00000109, 1'b1);
        chk(trig_word == 64'h0000_1234_5678_0009, "R10 reuse", trig_word, 64'h0000_1234_5678_0009);
        accept();

        // R4: start with bit 8 clear
        wr(A_STA, 32'h0000000E, 1'b1);
        chk(trig_valid == 1'b0, "R4 no launch", 64'(trig_valid), 64'h0);
        chk(start_overrun == 1'b0, "R4 no overrun", 64'(start_overrun), 64'h0);

        // R9: other address and strobe low
        wr(16'h0111, 32'hAAAA_AAAA, 1'b1);
        wr(A_PRE, 32'h5555_5555, 1'b0);
        wr(A_STA, 32'h0000010F, 1'b0);
        chk(trig_valid == 1'b0, "R9 no launch", 64'(trig_valid), 64'h0);
        wr(A_STA, 32'h00000101, 1'b1);
        chk(trig_word == 64'h0000_1234_5678_0001, "R9 preload kept", trig_word, 64'h0000_1234_5678_0001);

        // R5: stall holds
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(trig_valid && trig_word == 64'h0000_1234_5678_0001, "R5 hold",
                trig_word, 64'h0000_1234_5678_0001);
        end

        // R8: preload during pending
        wr(A_PRE, 32'h0102_0304, 1'b1);
        chk(trig_word == 64'h0000_1234_5678_0001, "R8 in flight", trig_word, 64'h0000_1234_5678_0001);
        chk(start_overrun == 1'b0, "R8 no overrun", 64'(start_overrun), 64'h0);

        // R6: start while pending
        wr(A_STA, 32'h0000010A, 1'b1);
        chk(trig_word == 64'h0000_1234_5678_0001, "R6 word kept", trig_word, 64'h0000_1234_5678_0001);
        chk(start_overrun == 1'b1, "R6 overrun", 64'(start_overrun), 64'h1);

        // R6: start in the acceptance cycle is dropped too
        @(negedge clk);
        trig_ready = 1'b1;
        reg_addr   = A_STA;
        reg_wdata  = 32'h0000010B;
        reg_we     = 1'b1;
        @(negedge clk);
        trig_ready = 1'b0;
        reg_we     = 1'b0;
        chk(trig_valid == 1'b0, "R6 accept-cycle drop", 64'(trig_valid), 64'h0);

        // R8: next start uses new preload; R7 sticky
        wr(A_STA, 32'h00000102, 1'b1);
        chk(trig_word == 64'h0000_0102_0304_0002, "R8 new preload", trig_word, 64'h0000_0102_0304_0002);
        accept();
        chk(start_overrun == 1'b1, "R7 sticky", 64'(start_overrun), 64'h1);

        // R7: cleared only by reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(start_overrun == 1'b0, "R7 reset clears", 64'(start_overrun), 64'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule